// File: doc/BRIEF.md
# Serial Memory Controller Interrupt Raw Status

This block gathers event indications from a serial memory controller into one 32-bit word of sticky raw interrupt bits. Its inputs are the slave-side and master-side state-machine states, per-read ECC error pulses tagged by target (flash or external RAM), an access-rejected pulse, and three AXI error pulses. An AXI read address or an AXI write address can fail the address-map check, and an AXI write can be aimed at flash.

The two state-end bits fire on the transition into the idle state, not on idle itself. The ECC bit is driven by an 8-bit running error count. Two static source enables choose which ECC errors are counted: flash errors, RAM errors, both, or none. The bit fires once a counted error brings the count to at least a static 8-bit threshold.

Software reads the raw word and clears bits with a write-one-to-clear port. Clearing the ECC bit also restarts the error count. Masking, enables and final interrupt gating are left to the logic downstream.

Top module: `memctl_irq_raw`

## Requirements
- R1: Raw bit positions are fixed: slave state end at bit 3, master state end at bit 4, ECC error at bit 5, access reject at bit 6, AXI read-address error at bit 7, AXI write-to-flash at bit 8, AXI write-address error at bit 9. Bits 0 to 2 and 10 to 31 always read 0.
- R2: Bit 3 sets one cycle after a cycle in which the slave state equals the idle code (0) and the slave state in the previous cycle was not idle. A slave state that stays idle never sets it.
- R3: Bit 4 follows the same rule as bit 3, applied to the master state.
- R4: With only the flash enable set, each flash ECC error adds one to the count and RAM errors are ignored. Bit 5 sets one cycle after the flash error that brings the count to at least the threshold.
- R5: With only the RAM enable set, only RAM errors are counted. With both enables set, flash and RAM errors are summed into the same count. In every case bit 5 sets one cycle after the counted error that reaches the threshold.
- R6: With both enables clear, no ECC error is counted and bit 5 never sets.
- R7: The ECC error count saturates at 255. Writing 1 to bit 5 through the clear port resets the count to zero.
- R8: Bit 6 sets one cycle after a reject pulse. Bits 7, 8 and 9 set one cycle after an AXI read-address error pulse, an AXI write-to-flash pulse and an AXI write-address error pulse, respectively.
- R9: Every raw bit is sticky until a clear write with a 1 in its position. A set event and a clear of the same bit in the same cycle leave the bit set. Clear writes with 0 in a position do not change that bit.
- R10: A synchronous active-high reset returns the raw word, the error count and the stored previous states to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slv_state_i | input | 4 | Current slave state, 0 is idle |
| mst_state_i | input | 4 | Current master state, 0 is idle |
| ecc_err_vld_i | input | 1 | One ECC read error this cycle |
| ecc_err_ram_i | input | 1 | Error target: 0 flash, 1 external RAM |
| ecc_flash_en_i | input | 1 | Count flash ECC errors |
| ecc_ram_en_i | input | 1 | Count RAM ECC errors |
| ecc_thresh_i | input | 8 | ECC error threshold |
| reject_i | input | 1 | Access-rejected pulse |
| axi_rd_addr_err_i | input | 1 | AXI read address failed map check |
| axi_wr_flash_i | input | 1 | AXI write aimed at flash |
| axi_wr_addr_err_i | input | 1 | AXI write address failed map check |
| clr_we_i | input | 1 | Clear write strobe |
| clr_data_i | input | 32 | Write-one-to-clear mask |
| raw_status_o | output | 32 | Raw interrupt status word |

## Verification
Every raw bit is due exactly one clock after the cycle in which its cause appears on the inputs. This holds for a state input reaching idle, for a counted ECC error that reaches the threshold, and for any event pulse. A clear write likewise takes effect one clock later. The bench drives inputs on the falling edge and reads the word on the next falling edge, so exactly one rising edge lies between cause and observation. A behavioural model updated on each rising edge is compared on every falling edge. Named checks at the due edge cover the ECC cases that must stay low one error before the threshold, the idle-hold case, and the simultaneous set-and-clear case.

// File: rtl/memctl_irq_pkg.sv
package memctl_irq_pkg;
    localparam int unsigned RAW_W      = 32;
    localparam int unsigned BIT_SLV    = 3;
    localparam int unsigned BIT_MST    = 4;
    localparam int unsigned BIT_ECC    = 5;
    localparam int unsigned BIT_REJ    = 6;
    localparam int unsigned BIT_RADDR  = 7;
    localparam int unsigned BIT_WFLASH = 8;
    localparam int unsigned BIT_WADDR  = 9;
    localparam logic [RAW_W-1:0] IMPL_MASK = 32'h0000_03F8;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_FLASH = 2'b01,
        SRC_RAM   = 2'b10,
        SRC_BOTH  = 2'b11
    } ecc_src_sel_e;
endpackage

// File: rtl/memctl_state_end_det.sv
module memctl_state_end_det #(
    parameter int unsigned SW        = 4,
    parameter logic [SW-1:0] IDLE_CODE = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] state_i,
    output logic          end_o
);
    typedef struct packed {
        logic [SW-1:0] prev;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.prev = state_i;
        end_o      = (det_q.prev != IDLE_CODE) && (state_i == IDLE_CODE);
    end

    always_ff @(posedge clk) begin
        if (rst) det_q <= '{prev: IDLE_CODE};
        else     det_q <= det_d;
    end

    // R2 / R3: idle held over two cycles never signals an end
    assert_no_end_while_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (state_i == IDLE_CODE) |=> (state_i != IDLE_CODE || !end_o));
endmodule

// File: rtl/memctl_ecc_thresh.sv
module memctl_ecc_thresh
    import memctl_irq_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          err_vld_i,
    input  logic          err_ram_i,
    input  logic          flash_en_i,
    input  logic          ram_en_i,
    input  logic [CW-1:0] thresh_i,
    input  logic          cnt_clr_i,
    output logic          hit_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ecc_t;

    ecc_t          ecc_d, ecc_q;
    ecc_src_sel_e  src_sel;
    logic          counted;
    logic [CW:0]   sum;
    logic [CW-1:0] sat;

    always_comb begin
        src_sel = ecc_src_sel_e'({ram_en_i, flash_en_i});
        unique case (src_sel)
            SRC_FLASH: counted = err_vld_i && !err_ram_i;
            SRC_RAM:   counted = err_vld_i &&  err_ram_i;
            SRC_BOTH:  counted = err_vld_i;
            default:   counted = 1'b0;
        endcase
        sum   = {1'b0, ecc_q.cnt} + {{CW{1'b0}}, counted};
        sat   = sum[CW] ? CNT_MAX : sum[CW-1:0];
        hit_o = counted && (sat >= thresh_i);
        ecc_d = ecc_q;
        ecc_d.cnt = cnt_clr_i ? '0 : sat;
    end

    always_ff @(posedge clk) begin
        if (rst) ecc_q <= '0;
        else     ecc_q <= ecc_d;
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (ecc_q.cnt == CNT_MAX && !cnt_clr_i) |=> (ecc_q.cnt == CNT_MAX));
    assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_clr_i |=> (ecc_q.cnt == '0));
    assert_no_source_R6: assert property (@(posedge clk) disable iff (rst)
        (!flash_en_i && !ram_en_i && !cnt_clr_i) |=> $stable(ecc_q.cnt));
endmodule

// File: rtl/memctl_raw_bank.sv
module memctl_raw_bank #(
    parameter int unsigned NB = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] set_i,
    input  logic [NB-1:0] clr_i,
    output logic [NB-1:0] raw_o
);
    typedef struct packed {
        logic [NB-1:0] raw;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NB; i++) begin
            if (set_i[i])      bank_d.raw[i] = 1'b1;
            else if (clr_i[i]) bank_d.raw[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    assign raw_o = bank_q.raw;

    for (genvar g = 0; g < NB; g++) begin : g_bit_chk
        assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
            (bank_q.raw[g] && !clr_i[g]) |=> bank_q.raw[g]);
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> bank_q.raw[g]);
        assert_rise_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(bank_q.raw[g]) |-> $past(set_i[g]));
    end
endmodule

// File: rtl/memctl_irq_raw.sv
module memctl_irq_raw
    import memctl_irq_pkg::*;
#(
    parameter int unsigned SW = 4,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] slv_state_i,
    input  logic [SW-1:0] mst_state_i,
    input  logic          ecc_err_vld_i,
    input  logic          ecc_err_ram_i,
    input  logic          ecc_flash_en_i,
    input  logic          ecc_ram_en_i,
    input  logic [CW-1:0] ecc_thresh_i,
    input  logic          reject_i,
    input  logic          axi_rd_addr_err_i,
    input  logic          axi_wr_flash_i,
    input  logic          axi_wr_addr_err_i,
    input  logic          clr_we_i,
    input  logic [RAW_W-1:0] clr_data_i,
    output logic [RAW_W-1:0] raw_status_o
);
    localparam int unsigned NDET = 2;

    logic [NDET-1:0]  det_end;
    logic [SW-1:0]    det_state [NDET];
    logic             ecc_hit;
    logic             ecc_cnt_clr;
    logic [RAW_W-1:0] set_vec;
    logic [RAW_W-1:0] clr_vec;

    assign det_state[0] = slv_state_i;
    assign det_state[1] = mst_state_i;

    for (genvar d = 0; d < NDET; d++) begin : g_det
        memctl_state_end_det #(.SW(SW), .IDLE_CODE('0)) det_i (
            .clk     (clk),
            .rst     (rst),
            .state_i (det_state[d]),
            .end_o   (det_end[d])
        );
    end

    always_comb begin
        clr_vec     = clr_we_i ? (clr_data_i & IMPL_MASK) : '0;
        ecc_cnt_clr = clr_vec[BIT_ECC];
        set_vec                = '0;
        set_vec[BIT_SLV]       = det_end[0];
        set_vec[BIT_MST]       = det_end[1];
        set_vec[BIT_ECC]       = ecc_hit;
        set_vec[BIT_REJ]       = reject_i;
        set_vec[BIT_RADDR]     = axi_rd_addr_err_i;
        set_vec[BIT_WFLASH]    = axi_wr_flash_i;
        set_vec[BIT_WADDR]     = axi_wr_addr_err_i;
    end

    memctl_ecc_thresh #(.CW(CW)) ecc_i (
        .clk        (clk),
        .rst        (rst),
        .err_vld_i  (ecc_err_vld_i),
        .err_ram_i  (ecc_err_ram_i),
        .flash_en_i (ecc_flash_en_i),
        .ram_en_i   (ecc_ram_en_i),
        .thresh_i   (ecc_thresh_i),
        .cnt_clr_i  (ecc_cnt_clr),
        .hit_o      (ecc_hit)
    );

    memctl_raw_bank #(.NB(RAW_W)) bank_i (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .raw_o (raw_status_o)
    );

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (raw_status_o & ~IMPL_MASK) == '0);
    assert_reject_sets_R8: assert property (@(posedge clk) disable iff (rst)
        reject_i |=> raw_status_o[BIT_REJ]);
    assert_ecc_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (!ecc_flash_en_i && !ecc_ram_en_i && !raw_status_o[BIT_ECC]) |=> !raw_status_o[BIT_ECC]);
endmodule

// File: tb/memctl_irq_raw_tb_top.sv
module memctl_irq_raw_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  slv_state = '0, mst_state = '0;
    logic        ecc_vld = 0, ecc_ram = 0, fl_en = 0, ram_en = 0;
    logic [7:0]  thresh = '0;
    logic        reject = 0, raddr = 0, wflash = 0, waddr = 0;
    logic        clr_we = 0;
    logic [31:0] clr_data = '0;
    logic [31:0] raw;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int unsigned m_raw = 0;
    int          m_cnt = 0;
    int          m_prev_s = 0, m_prev_m = 0;

    always #2 clk = ~clk;

    memctl_irq_raw dut_i (
        .clk(clk), .rst(rst),
        .slv_state_i(slv_state), .mst_state_i(mst_state),
        .ecc_err_vld_i(ecc_vld), .ecc_err_ram_i(ecc_ram),
        .ecc_flash_en_i(fl_en), .ecc_ram_en_i(ram_en),
        .ecc_thresh_i(thresh), .reject_i(reject),
        .axi_rd_addr_err_i(raddr), .axi_wr_flash_i(wflash),
        .axi_wr_addr_err_i(waddr), .clr_we_i(clr_we),
        .clr_data_i(clr_data), .raw_status_o(raw)
    );

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        int unsigned setm, clrm;
        int counted, nc;
        if (rst) begin
            m_raw = 0; m_cnt = 0; m_prev_s = 0; m_prev_m = 0;
        end else begin
            setm = 0;
            if (m_prev_s != 0 && slv_state == 0) setm |= (1 << 3);
            if (m_prev_m != 0 && mst_state == 0) setm |= (1 << 4);
            counted = (ecc_vld && ((ecc_ram && ram_en) || (!ecc_ram && fl_en))) ? 1 : 0;
            nc = m_cnt + counted;
            if (nc > 255) nc = 255;
            if (counted == 1 && nc >= int'(thresh)) setm |= (1 << 5);
            if (reject) setm |= (1 << 6);
            if (raddr)  setm |= (1 << 7);
            if (wflash) setm |= (1 << 8);
            if (waddr)  setm |= (1 << 9);
            clrm = clr_we ? clr_data : 0;
            m_raw = ((m_raw & ~clrm) | setm) & 32'h3F8;
            m_cnt = clrm[5] ? 0 : nc;
            m_prev_s = slv_state;
            m_prev_m = mst_state;
        end
    end

    always @(negedge clk) begin
        cycles++;
        checks++;
        if (raw !== m_raw) begin
            errors++;
            $display("FAIL R1 R9 model compare: actual %h expected %h", raw, m_raw);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired (R10 run length): actual %0d expected <= 20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic chk(string tag, logic actual, logic expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, actual, expected);
        end
    endtask

    task automatic w1c(logic [31:0] m);
        clr_we = 1; clr_data = m; tick(); clr_we = 0; clr_data = '0;
    endtask

    task automatic ecc_err(logic to_ram);
        ecc_vld = 1; ecc_ram = to_ram; tick(); ecc_vld = 0; ecc_ram = 0;
    endtask

    initial begin
        repeat (3) tick();
        checks++;
        if (raw !== 32'h0) begin errors++; $display("FAIL R10 reset: actual %h expected 0", raw); end
        rst = 0;
        tick();

        // R2 idle hold never sets; transition sets one cycle later
        repeat (4) tick();
        chk("R2 idle hold", raw[3], 1'b0);
        slv_state = 4'd5; tick(); chk("R2 busy", raw[3], 1'b0);
        slv_state = 4'd0; tick(); chk("R2 end", raw[3], 1'b1);
        w1c(32'h8); chk("R9 clear bit3", raw[3], 1'b0);

        // R3 master
        mst_state = 4'd2; tick(); mst_state = 4'd9; tick(); chk("R3 busy", raw[4], 1'b0);
        mst_state = 4'd0; tick(); chk("R3 end", raw[4], 1'b1);
        w1c(32'h10);

        // R4 flash only, threshold 3
        fl_en = 1; thresh = 8'd3;
        ecc_err(0); ecc_err(0); ecc_err(1);
        chk("R4 below threshold", raw[5], 1'b0);
        ecc_err(0); chk("R4 threshold reached", raw[5], 1'b1);
        // R7 clear restarts count
        w1c(32'h20); chk("R7 clear bit5", raw[5], 1'b0);
        ecc_err(0); ecc_err(0); chk("R7 count restarted", raw[5], 1'b0);
        ecc_err(0); chk("R7 reach after restart", raw[5], 1'b1);
        w1c(32'h20);

        // R5 RAM only, threshold 2
        fl_en = 0; ram_en = 1; thresh = 8'd2;
        ecc_err(0); ecc_err(1); chk("R5 ram only, flash ignored", raw[5], 1'b0);
        ecc_err(1); chk("R5 ram only reach", raw[5], 1'b1);
        w1c(32'h20);

        // R5 both, threshold 2
        fl_en = 1; ram_en = 1;
        ecc_err(0); chk("R5 both one error", raw[5], 1'b0);
        ecc_err(1); chk("R5 both summed", raw[5], 1'b1);
        w1c(32'h20);

        // R6 none enabled
        fl_en = 0; ram_en = 0; thresh = 8'd1;
        repeat (5) ecc_err(0);
        repeat (5) ecc_err(1);
        chk("R6 disabled", raw[5], 1'b0);

        // R7 high threshold with saturation
        fl_en = 1; thresh = 8'd255;
        repeat (254) ecc_err(0);
        chk("R7 254 of 255", raw[5], 1'b0);
        ecc_err(0); chk("R7 255 reached", raw[5], 1'b1);
        repeat (10) ecc_err(0);
        w1c(32'h20); chk("R7 cleared after saturation", raw[5], 1'b0);
        fl_en = 0;

        // R8 event bits
        reject = 1; tick(); reject = 0; chk("R8 reject", raw[6], 1'b1);
        raddr  = 1; tick(); raddr  = 0; chk("R8 rd addr", raw[7], 1'b1);
        wflash = 1; tick(); wflash = 0; chk("R8 wr flash", raw[8], 1'b1);
        waddr  = 1; tick(); waddr  = 0; chk("R8 wr addr", raw[9], 1'b1);

        // R9 partial clear and set-wins
        w1c(32'h80);
        chk("R9 cleared bit7", raw[7], 1'b0);
        chk("R9 bit8 untouched", raw[8], 1'b1);
        reject = 1; clr_we = 1; clr_data = 32'h40; tick();
        reject = 0; clr_we = 0; clr_data = '0;
        chk("R9 set wins", raw[6], 1'b1);

        // R1 reserved bits after full clear
        w1c(32'hFFFF_FFFF);
        checks++;
        if (raw !== 32'h0) begin errors++; $display("FAIL R1 all clear: actual %h expected 0", raw); end

        // R10 reset mid-run
        reject = 1; tick(); reject = 0;
        rst = 1; tick(); rst = 0;
        checks++;
        if (raw !== 32'h0) begin errors++; $display("FAIL R10 reset clears: actual %h expected 0", raw); end
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule